// File: doc/BRIEF.md
# Double-Buffered Read-Once Line Data Store

This block sits between a line receiver and a serial host-bus slave. As the receiver captures the words of a data line, the block keeps the five words that matter in a receive bank. A line that ends without a biphase error is a good line. After a good line, the block copies the receive bank into a transmit bank and raises a new-data flag. The host reads the transmit bank one byte at a time through a request strobe. The bytes come out in a fixed order that differs from the order they arrived in. After one complete read the data counts as used: the flag drops, and every later byte is all ones until another good line arrives. The bit-level bus protocol and address matching live in the slave, which reports to this block only whether the device is addressed, when a start or stop condition is seen, and when a byte is wanted.

The copy controller has two states. `XF_IDLE` has nothing pending. `XF_HOLD` has a good line waiting for the bus to let go. The controller takes these transitions:
- **copy-now**: `XF_IDLE` copies at once after a good line, unless the device is addressed with no bus event in that cycle.
- **defer**: in that case, `XF_IDLE` moves to `XF_HOLD` instead.
- **release**: in `XF_HOLD`, a start or stop copies and returns to `XF_IDLE`.
- **cancel**: in `XF_HOLD`, capture of a kept word returns to `XF_IDLE` with no copy.
- **re-arm**: in `XF_HOLD`, another good line either stays in `XF_HOLD` or copies, under the same rule as `XF_IDLE`.

The read sequencer also has two states. `RD_IDLE` has no read under way. `RD_ACTIVE` has a read partly served. Its transitions are:
- **first-byte**: a byte request in `RD_IDLE` enters `RD_ACTIVE`.
- **last-byte**: serving the fifth byte returns to `RD_IDLE` and completes the read.
- **stop-end**: a stop in `RD_ACTIVE` completes the read.
- **restart**: a start in `RD_ACTIVE` returns to `RD_IDLE` and rewinds to the first byte without completing the read.

Top module: `line_word_vault`

## Requirements
- R1: After reset, `data_avail` is 0, `tx_vld` is 0, `tx_byte` is 8'hFF, and no copy is pending.
- R2: A capture strobe `rx_wr` with `rx_word` equal to 5, 11, 12, 13 or 14 (word numbers 1 to 15) stores `rx_data` in the receive bank. A strobe with any other word number leaves the bank as it was.
- R3: In the cycle where `line_done` is 1 with `line_err` 0, the block copies the receive bank into the transmit bank. It does so when the device is not addressed, or when `bus_start` or `bus_stop` is 1 in that cycle. `data_avail` is 1 from the next cycle.
- R4: A line that ends with `line_err` 1 copies nothing. The transmit bank and `data_avail` keep their values.
- R5: A good line that ends while `bus_addressed` is 1 with no bus event waits. The copy happens at the next `bus_start` or `bus_stop`, and `data_avail` stays 0 until then.
- R6: Capture of a kept word while a copy waits cancels the wait. A later good line arms the wait again, so exactly one copy occurs, carrying the newest line.
- R7: Each `byte_req` yields, one cycle later, `tx_vld` = 1 with the next byte. The order is word 11, 12, 13, 14, then word 5.
- R8: A byte requested while `data_avail` is 0 is 8'hFF.
- R9: A read completes when the fifth byte is requested, or when `bus_stop` arrives after at least one byte. Completion clears `data_avail`. A copy in the same cycle takes precedence.
- R10: A `bus_start` in the middle of a read rewinds the order to word 11 and does not complete the read.
- R11: `data_avail` is 1 exactly while the new-data flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_wr | input | 1 | Captured-word strobe from receiver |
| rx_word | input | 4 | Word number of captured byte (1..15) |
| rx_data | input | 8 | Captured byte |
| line_done | input | 1 | Line finished strobe |
| line_err | input | 1 | Biphase error seen on the finished line |
| bus_addressed | input | 1 | Slave is currently addressed |
| bus_start | input | 1 | Start condition seen (pulse) |
| bus_stop | input | 1 | Stop condition seen (pulse) |
| byte_req | input | 1 | Host wants the next byte (pulse) |
| tx_byte | output | 8 | Byte for the host |
| tx_vld | output | 1 | `tx_byte` was updated for a request |
| data_avail | output | 1 | Fresh unread data present |

## Verification
The hardest case to reach is a deferred copy that another line overtakes. The bench must hold `bus_addressed` high across two complete lines and then end the wait with a stop. The read that follows must return only the second line's words, and `data_avail` must have stayed low the whole time. The bench also builds the cancel case: an errored line lands while a copy waits, and after the stop no data becomes available. A third sequence puts a restart inside a partial read, so that the rewind and the non-completion are both seen through the byte order and `data_avail`.

// File: rtl/vault_pkg.sv
package vault_pkg;

    localparam int NUM_SLOTS = 5;

    typedef enum logic {
        XF_IDLE,
        XF_HOLD
    } xfer_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_ACTIVE
    } rd_state_e;

    typedef struct packed {
        logic       hit;
        logic [2:0] slot;
    } slot_map_t;

    // Slot index equals read position: 11,12,13,14 then 5.
    function automatic slot_map_t map_word(input logic [3:0] word);
        slot_map_t m;
        m.hit  = 1'b1;
        m.slot = 3'd0;
        unique case (word)
            4'd11:   m.slot = 3'd0;
            4'd12:   m.slot = 3'd1;
            4'd13:   m.slot = 3'd2;
            4'd14:   m.slot = 3'd3;
            4'd5:    m.slot = 3'd4;
            default: m.hit  = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wv_rx_bank.sv
module wv_rx_bank
    import vault_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NSLOT  = NUM_SLOTS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [3:0]                   word,
    input  logic [BYTE_W-1:0]            data,
    output logic [NSLOT-1:0][BYTE_W-1:0] bank,
    output logic                         kept_wr
);
    slot_map_t m;

    always_comb begin
        m       = map_word(word);
        kept_wr = wr && m.hit;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[s] <= '0;
            end else if (kept_wr && (int'(m.slot) == s)) begin
                bank[s] <= data;
            end
        end
    end

endmodule

// File: rtl/wv_xfer_ctrl.sv
module wv_xfer_ctrl
    import vault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_done,
    input  logic line_err,
    input  logic addressed,
    input  logic bus_start,
    input  logic bus_stop,
    input  logic kept_wr,
    input  logic read_done,
    output logic load,
    output logic new_flag
);
    xfer_state_e st_q, st_d;
    logic        good_line;
    logic        bus_evt;
    logic        flag_q;

    assign good_line = line_done && !line_err;
    assign bus_evt   = bus_start || bus_stop;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= XF_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            XF_IDLE: begin
                if (good_line) begin
                    if (addressed && !bus_evt) st_d = XF_HOLD;
                    else                       load = 1'b1;
                end
            end
            XF_HOLD: begin
                if (good_line) begin
                    if (addressed && !bus_evt) st_d = XF_HOLD;
                    else begin
                        load = 1'b1;
                        st_d = XF_IDLE;
                    end
                end else if (kept_wr) begin
                    st_d = XF_IDLE;
                end else if (bus_evt) begin
                    load = 1'b1;
                    st_d = XF_IDLE;
                end
            end
            default: st_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (load)      flag_q <= 1'b1;
        else if (read_done) flag_q <= 1'b0;
    end

    assign new_flag = flag_q;

    p_err_no_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done && line_err && st_q == XF_IDLE && !flag_q) |=> !flag_q);

    p_hold_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == XF_HOLD && !bus_evt && !kept_wr && !line_done && !flag_q)
        |=> (!flag_q && st_q == XF_HOLD));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (read_done && !load) |=> !flag_q);

    p_copy_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (good_line && !addressed) |=> flag_q);

endmodule

// File: rtl/wv_reader.sv
module wv_reader
    import vault_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NSLOT  = NUM_SLOTS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         byte_req,
    input  logic                         bus_start,
    input  logic                         bus_stop,
    input  logic                         new_flag,
    input  logic [NSLOT-1:0][BYTE_W-1:0] bank,
    output logic [BYTE_W-1:0]            tx_byte,
    output logic                         tx_vld,
    output logic                         read_done
);
    localparam int                PTR_W = $clog2(NSLOT);
    localparam logic [PTR_W-1:0]  LAST  = PTR_W'(NSLOT - 1);

    rd_state_e        st_q, st_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [BYTE_W-1:0] pick;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RD_IDLE;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        ptr_d     = ptr_q;
        read_done = 1'b0;
        unique case (st_q)
            RD_IDLE: begin
                if (byte_req) begin
                    ptr_d = ptr_q + 1'b1;
                    st_d  = RD_ACTIVE;
                end
            end
            RD_ACTIVE: begin
                if (byte_req) begin
                    if (ptr_q == LAST) begin
                        read_done = 1'b1;
                        ptr_d     = '0;
                        st_d      = RD_IDLE;
                    end else begin
                        ptr_d = ptr_q + 1'b1;
                    end
                end else if (bus_stop) begin
                    read_done = 1'b1;
                    ptr_d     = '0;
                    st_d      = RD_IDLE;
                end else if (bus_start) begin
                    ptr_d = '0;
                    st_d  = RD_IDLE;
                end
            end
            default: begin
                st_d  = RD_IDLE;
                ptr_d = '0;
            end
        endcase
    end

    assign pick = new_flag ? bank[ptr_q] : {BYTE_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= {BYTE_W{1'b1}};
            tx_vld  <= 1'b0;
        end else begin
            tx_vld <= byte_req;
            if (byte_req) tx_byte <= pick;
        end
    end

    p_blank_when_stale_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && !new_flag) |=> (tx_vld && tx_byte == {BYTE_W{1'b1}}));

    p_vld_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |=> tx_vld);

    p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);

    p_restart_rewinds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RD_ACTIVE && bus_start && !bus_stop && !byte_req)
        |=> (ptr_q == '0 && st_q == RD_IDLE));

endmodule

// File: rtl/line_word_vault.sv
module line_word_vault
    import vault_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_wr,
    input  logic [3:0]        rx_word,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              line_done,
    input  logic              line_err,
    input  logic              bus_addressed,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              byte_req,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_vld,
    output logic              data_avail
);
    localparam int NSLOT = NUM_SLOTS;

    logic [NSLOT-1:0][BYTE_W-1:0] rx_bank;
    logic [NSLOT-1:0][BYTE_W-1:0] tx_bank;
    logic kept_wr, load, new_flag, read_done;

    wv_rx_bank #(.BYTE_W(BYTE_W), .NSLOT(NSLOT)) u_rx (
        .clk(clk), .rst_n(rst_n), .wr(rx_wr), .word(rx_word),
        .data(rx_data), .bank(rx_bank), .kept_wr(kept_wr)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_tx
        always_ff @(posedge clk) begin
            if (!rst_n)    tx_bank[s] <= '0;
            else if (load) tx_bank[s] <= rx_bank[s];
        end
    end

    wv_xfer_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .line_done(line_done), .line_err(line_err),
        .addressed(bus_addressed), .bus_start(bus_start), .bus_stop(bus_stop),
        .kept_wr(kept_wr), .read_done(read_done), .load(load), .new_flag(new_flag)
    );

    wv_reader #(.BYTE_W(BYTE_W), .NSLOT(NSLOT)) u_rd (
        .clk(clk), .rst_n(rst_n), .byte_req(byte_req), .bus_start(bus_start),
        .bus_stop(bus_stop), .new_flag(new_flag), .bank(tx_bank),
        .tx_byte(tx_byte), .tx_vld(tx_vld), .read_done(read_done)
    );

    assign data_avail = new_flag;

    p_bank_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(tx_bank));

    p_rise_needs_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_avail) |-> $past(line_done || bus_start || bus_stop));

endmodule

// File: tb/line_word_vault_bench.sv
module line_word_vault_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_wr = 1'b0;
    logic [3:0] rx_word = '0;
    logic [7:0] rx_data = '0;
    logic       line_done = 1'b0, line_err = 1'b0;
    logic       bus_addressed = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
    logic       byte_req = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_vld, data_avail;

    int vectors = 0;
    int misses  = 0;
    bit ended   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    line_word_vault u_line_word_vault (
        .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_word(rx_word),
        .rx_data(rx_data), .line_done(line_done), .line_err(line_err),
        .bus_addressed(bus_addressed), .bus_start(bus_start), .bus_stop(bus_stop),
        .byte_req(byte_req), .tx_byte(tx_byte), .tx_vld(tx_vld),
        .data_avail(data_avail)
    );

    always #5ns clk = ~clk;

    function automatic logic [7:0] val(input int w, input int seed);
        return {4'(w), 4'(seed)};
    endfunction

    function automatic int word_at(input int pos);
        case (pos)
            0: return 11;
            1: return 12;
            2: return 13;
            3: return 14;
            default: return 5;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected bytes as the design returns them.
    always @(negedge clk) begin
        if (rst_n && tx_vld) begin
            if (exp_q.size() == 0) begin
                vectors++;
                misses++;
                $display("FAIL R7 actual=%0h expected=none (unexpected byte)", tx_byte);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                check(t, tx_byte, e);
            end
        end
    end

    task automatic put_line(input int seed, input bit err);
        for (int w = 1; w <= 15; w++) begin
            @(negedge clk);
            rx_wr = 1'b1; rx_word = 4'(w); rx_data = val(w, seed);
        end
        @(negedge clk);
        rx_wr = 1'b0; line_done = 1'b1; line_err = err;
        @(negedge clk);
        line_done = 1'b0; line_err = 1'b0;
    endtask

    task automatic read_bytes(input int first, input int n, input int seed,
                              input bit fresh, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_req = 1'b1;
            exp_q.push_back(fresh ? val(word_at(first + i), seed) : 8'hFF);
            tag_q.push_back(tag);
            @(negedge clk);
            byte_req = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            misses++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 data_avail", data_avail, 0);
        check("R1 tx_vld", tx_vld, 0);
        check("R1 tx_byte", tx_byte, 8'hFF);
        // R8 stale read after reset
        read_bytes(0, 5, 0, 1'b0, "R8");

        // R3 R2 R7 good line, direct copy, read order
        put_line(1, 1'b0);
        check("R3 data_avail after good line", data_avail, 1);
        // R4 errored line keeps older data and flag
        put_line(9, 1'b1);
        check("R4 flag kept", data_avail, 1);
        read_bytes(0, 5, 1, 1'b1, "R7 order");
        check("R9 full read clears", data_avail, 0);
        read_bytes(0, 5, 0, 1'b0, "R8 after read");

        // R4 errored line with no data
        put_line(2, 1'b1);
        check("R4 no copy", data_avail, 0);

        // R2 non-kept word ignored: overwrite word 6 only, then good done
        put_line(3, 1'b0);
        @(negedge clk); rx_wr = 1'b1; rx_word = 4'd6; rx_data = 8'h00;
        @(negedge clk); rx_wr = 1'b0; line_done = 1'b1;
        @(negedge clk); line_done = 1'b0;
        read_bytes(0, 5, 3, 1'b1, "R2 ignore");

        // R5 deferral while addressed
        bus_addressed = 1'b1;
        put_line(4, 1'b0);
        repeat (4) @(negedge clk);
        check("R5 deferred", data_avail, 0);
        pulse_start();
        check("R5 released by start", data_avail, 1);
        bus_addressed = 1'b0;
        // R9 partial read then stop
        read_bytes(0, 2, 4, 1'b1, "R9 partial");
        check("R9 before stop", data_avail, 1);
        pulse_stop();
        check("R9 stop clears", data_avail, 0);
        read_bytes(0, 1, 0, 1'b0, "R8 after stop");
        pulse_stop();

        // R6 newer line replaces a pending one
        bus_addressed = 1'b1;
        put_line(5, 1'b0);
        put_line(6, 1'b0);
        check("R6 still waiting", data_avail, 0);
        pulse_stop();
        bus_addressed = 1'b0;
        check("R6 single copy", data_avail, 1);
        read_bytes(0, 5, 6, 1'b1, "R6 newest");
        check("R6 consumed", data_avail, 0);

        // R6 errored line cancels pending copy
        bus_addressed = 1'b1;
        put_line(7, 1'b0);
        put_line(8, 1'b1);
        pulse_stop();
        bus_addressed = 1'b0;
        check("R6 cancel", data_avail, 0);

        // R10 restart mid-read
        put_line(10, 1'b0);
        read_bytes(0, 2, 10, 1'b1, "R10 first part");
        pulse_start();
        check("R10 not complete", data_avail, 1);
        read_bytes(0, 5, 10, 1'b1, "R10 rewound");
        check("R11 flag low after read", data_avail, 0);

        // R1 reset drops data
        put_line(11, 1'b0);
        check("R11 avail", data_avail, 1);
        do_reset();
        check("R1 reset clears", data_avail, 0);
        read_bytes(0, 5, 0, 1'b0, "R1 blank");

        repeat (3) @(negedge clk);
        check("R7 queue drained", exp_q.size(), 0);
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule